// File: doc/BRIEF.md
# Matrix Keypad Scanner with Telephone Key Encoding

This block scans a 4x4 matrix of switches. Each column line is pulled low in turn while the four row lines idle high through external pull-ups. A closed switch in the column that is low pulls its row low. After a column is selected, the block waits a programmable settling window before it judges the rows. If any row is low, the lowest-numbered low row is the key. The row and column are then turned into a 4-bit key code.

The code leaves on a valid/ready stream. The code and its valid stay unchanged until the consumer raises ready. While valid waits for ready, scanning stops and the selected column does not move. After a transfer, the block keeps the same column selected until every row reads high again. Only then does it move on, so a held key gives one code. The row inputs are asynchronous and pass through a synchronizer of parameterized depth before the block judges them.

Top module: `keypad_scan_top`

## Requirements
- R1: During and right after reset, column 0 alone is driven low (`col_n_o` = 4'b1110), `key_valid_o` is 0 and `key_code_o` is 0.
- R2: At every cycle, exactly one bit of `col_n_o` is 0.
- R3: With no key pressed, the selected column advances 0, 1, 2, 3, 0, and each column stays selected for exactly SETTLE_CYC cycles.
- R4: For rows 0 to 2 and columns 0 to 2, the key code is row*3 + col + 1, which gives 1 to 9.
- R5: In column 3, the key code is 10 + row, which gives 0xA for row 0 through 0xD for row 3.
- R6: In row 3, column 0 gives 0xE, column 1 gives 0x0 and column 2 gives 0xF.
- R7: If several rows are low in the selected column, the lowest-numbered low row sets the code.
- R8: While `key_valid_o` is 1 and `key_ready_i` is 0, the next cycle keeps `key_valid_o` at 1, `key_code_o` unchanged and `col_n_o` unchanged, even if the key is released.
- R9: A transfer (valid and ready both 1) clears `key_valid_o` in the next cycle. No further valid is issued while any row stays low in the held column. After all rows read high, scanning resumes at the next column.
- R10: Rows are judged only at the last cycle of the settling window, through the synchronizer. A row that is low only early in the window and high again before its end produces no code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_n_i | input | 4 | Row sense lines, low while a key in the selected column is closed |
| col_n_o | output | 4 | Column drive lines, one low at a time |
| key_valid_o | output | 1 | Key code is valid |
| key_ready_i | input | 1 | Consumer accepts the key code |
| key_code_o | output | 4 | Encoded key value |

## Verification
A fault in the column counter or the dwell counter shows on `col_n_o` within one settling window. It appears as a column that repeats, gets skipped or stays too long, or as a step with two lines low. A fault in the handshake state shows within one cycle of a stall or a transfer. Valid drops while ready is low, the code or column changes during a stall, or valid repeats while the key is still held. A wrong mapping or a wrong priority shows on the first code issued for the affected key, which is at most one scan sweep after the press.

// File: rtl/keypad_pkg.sv
`timescale 1ns/1ps
package keypad_pkg;
  localparam int KP_ROWS  = 4;
  localparam int KP_COLS  = 4;
  localparam int KP_ROW_W = $clog2(KP_ROWS);
  localparam int KP_COL_W = $clog2(KP_COLS);
  localparam int KP_CODE_W = 4;

  typedef enum logic [1:0] {
    SC_SETTLE  = 2'd0,
    SC_HOLD    = 2'd1,
    SC_RELEASE = 2'd2
  } scan_state_t;

  // Telephone-style map: digits in the 3x3 block, letters in the last
  // column, star/zero/hash on the bottom row.
  function automatic logic [KP_CODE_W-1:0] map_key(
    input logic [KP_ROW_W-1:0] row,
    input logic [KP_COL_W-1:0] col
  );
    logic [KP_CODE_W-1:0] r4, c4;
    r4 = KP_CODE_W'(row);
    c4 = KP_CODE_W'(col);
    if (col == KP_COL_W'(KP_COLS - 1)) begin
      map_key = 4'hA + r4;
    end else if (row == KP_ROW_W'(KP_ROWS - 1)) begin
      case (col)
        KP_COL_W'(0): map_key = 4'hE;
        KP_COL_W'(1): map_key = 4'h0;
        default:      map_key = 4'hF;
      endcase
    end else begin
      map_key = r4 * 4'd3 + c4 + 4'd1;
    end
  endfunction
endpackage

// File: rtl/keypad_row_sync.sv
`timescale 1ns/1ps
module keypad_row_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= '1;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
      end
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/keypad_col_driver.sv
`timescale 1ns/1ps
module keypad_col_driver #(
  parameter int COLS       = 4,
  parameter int SETTLE_CYC = 255,
  localparam int COL_W = $clog2(COLS),
  localparam int CNT_W = $clog2(SETTLE_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  output logic [COL_W-1:0] col_idx_o,
  output logic [COLS-1:0]  col_n_o,
  output logic             settle_done_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

  logic [COL_W-1:0] col_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      cnt_q <= '0;
    end else if (advance_i) begin
      col_q <= (col_q == COL_LAST) ? '0 : col_q + COL_W'(1);
      cnt_q <= '0;
    end else if (cnt_q != CNT_LAST) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_drive
    assign col_n_o[c] = (col_q != COL_W'(c));
  end

  assign col_idx_o     = col_q;
  assign settle_done_o = (cnt_q == CNT_LAST);
endmodule

// File: rtl/keypad_row_encoder.sv
`timescale 1ns/1ps
module keypad_row_encoder
  import keypad_pkg::*;
(
  input  logic [KP_ROWS-1:0]   rows_n_i,
  input  logic [KP_COL_W-1:0]  col_idx_i,
  output logic                 hit_o,
  output logic [KP_CODE_W-1:0] code_o
);
  logic [KP_ROW_W-1:0] row_sel;

  always_comb begin
    row_sel = '0;
    for (int r = KP_ROWS - 1; r >= 0; r--) begin
      if (!rows_n_i[r]) row_sel = KP_ROW_W'(r);
    end
  end

  assign hit_o  = ~&rows_n_i;
  assign code_o = map_key(row_sel, col_idx_i);
endmodule

// File: rtl/keypad_scan_top.sv
`timescale 1ns/1ps
module keypad_scan_top
  import keypad_pkg::*;
#(
  parameter int SETTLE_CYC  = 255,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [KP_ROWS-1:0]   row_n_i,
  output logic [KP_COLS-1:0]   col_n_o,
  output logic                 key_valid_o,
  input  logic                 key_ready_i,
  output logic [KP_CODE_W-1:0] key_code_o
);
  logic [KP_ROWS-1:0]   rows_s;
  logic [KP_COL_W-1:0]  col_idx;
  logic                 settle_done;
  logic                 advance;
  logic                 hit;
  logic [KP_CODE_W-1:0] code_c;

  scan_state_t          state_q;
  logic                 valid_q;
  logic [KP_CODE_W-1:0] code_q;

  keypad_row_sync #(.WIDTH(KP_ROWS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (row_n_i),
    .sync_o  (rows_s)
  );

  keypad_col_driver #(.COLS(KP_COLS), .SETTLE_CYC(SETTLE_CYC)) u_cols (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .advance_i     (advance),
    .col_idx_o     (col_idx),
    .col_n_o       (col_n_o),
    .settle_done_o (settle_done)
  );

  keypad_row_encoder u_enc (
    .rows_n_i  (rows_s),
    .col_idx_i (col_idx),
    .hit_o     (hit),
    .code_o    (code_c)
  );

  always_comb begin
    advance = 1'b0;
    case (state_q)
      SC_SETTLE:  advance = settle_done && !hit;
      SC_RELEASE: advance = !hit;
      default:    advance = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SC_SETTLE;
      valid_q <= 1'b0;
      code_q  <= '0;
    end else begin
      case (state_q)
        SC_SETTLE: begin
          if (settle_done && hit) begin
            code_q  <= code_c;
            valid_q <= 1'b1;
            state_q <= SC_HOLD;
          end
        end
        SC_HOLD: begin
          if (key_ready_i) begin
            valid_q <= 1'b0;
            state_q <= SC_RELEASE;
          end
        end
        SC_RELEASE: begin
          if (!hit) state_q <= SC_SETTLE;
        end
        default: state_q <= SC_SETTLE;
      endcase
    end
  end

  assign key_valid_o = valid_q;
  assign key_code_o  = code_q;
endmodule

// File: rtl/keypad_scan_chk.sv
`timescale 1ns/1ps
module keypad_scan_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] col_n_o,
  input logic       key_valid_o,
  input logic       key_ready_i,
  input logic [3:0] key_code_o
);
  assert_one_col_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~col_n_o) == 1);

  assert_col_rotates_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(col_n_o) |-> col_n_o == {$past(col_n_o[2:0]), $past(col_n_o[3])});

  assert_hold_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o && !key_ready_i |=> key_valid_o && $stable(key_code_o));

  assert_hold_col_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o && !key_ready_i |=> $stable(col_n_o));

  assert_drop_after_xfer_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o && key_ready_i |=> !key_valid_o);
endmodule

bind keypad_scan_top keypad_scan_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .col_n_o     (col_n_o),
  .key_valid_o (key_valid_o),
  .key_ready_i (key_ready_i),
  .key_code_o  (key_code_o)
);

// File: tb/keypad_scan_top_tb.sv
`timescale 1ns/1ps
module keypad_scan_top_tb;
  localparam int SETTLE = 32;
  localparam int WAIT_MAX = 6 * SETTLE + 20;

  // {row[1:0], col[1:0], code[3:0]}
  localparam logic [7:0] VEC [16] = '{
    8'h01, 8'h12, 8'h23, 8'h3A,
    8'h44, 8'h55, 8'h66, 8'h7B,
    8'h87, 8'h98, 8'hA9, 8'hBC,
    8'hCE, 8'hD0, 8'hEF, 8'hFD
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] row_n;
  logic [3:0] col_n;
  logic       valid;
  logic       ready = 1'b1;
  logic [3:0] code;
  logic [15:0] pressed = '0; // bit r*4+c

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  // switch matrix model
  always_comb begin
    for (int r = 0; r < 4; r++) begin
      row_n[r] = 1'b1;
      for (int c = 0; c < 4; c++)
        if (pressed[r*4+c] && !col_n[c]) row_n[r] = 1'b0;
    end
  end

  keypad_scan_top #(.SETTLE_CYC(SETTLE), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .row_n_i(row_n), .col_n_o(col_n),
    .key_valid_o(valid), .key_ready_i(ready), .key_code_o(code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int i = 0; i < WAIT_MAX; i++) begin
      @(negedge clk);
      if (valid) begin got = 1'b1; break; end
    end
  endtask

  task automatic key_test(input int r, input int c, input int exp, input string req);
    bit got;
    pressed = '0;
    pressed[r*4+c] = 1'b1;
    wait_valid(got);
    chk(got, {req, " valid seen"}, int'(got), 1);
    if (got) begin
      chk(code == 4'(exp), req, int'(code), exp);
      chk(col_n == ~(4'b1 << c), {req, " column"}, int'(col_n), int'(~(4'b1 << c)));
    end
    pressed = '0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit got;
    int cnt;
    logic [3:0] prev, exp_col;
    logic [3:0] held;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(col_n == 4'b1110, "R1 col in reset", int'(col_n), 'hE);
    chk(!valid, "R1 valid in reset", int'(valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(col_n == 4'b1110 && !valid && code == 4'h0, "R1 after reset",
        int'({valid, code, col_n}), 'h0E);

    // R3 / R2 sweep with no key
    prev = col_n; cnt = 0;
    for (int n = 0; n < 5; ) begin
      @(negedge clk);
      cnt++;
      if (col_n != prev) begin
        exp_col = {prev[2:0], prev[3]};
        chk(col_n == exp_col, "R3 order", int'(col_n), int'(exp_col));
        chk($countones(~col_n) == 1, "R2 one column low", int'(col_n), int'(exp_col));
        if (n > 0) chk(cnt == SETTLE, "R3 dwell", cnt, SETTLE);
        prev = col_n; cnt = 0; n++;
      end
    end

    // R4 R5 R6 vector table over all keys
    foreach (VEC[i]) begin
      int r, c, e;
      r = int'(VEC[i][7:6]); c = int'(VEC[i][5:4]); e = int'(VEC[i][3:0]);
      if (c == 3)      key_test(r, c, e, "R5 letter key");
      else if (r == 3) key_test(r, c, e, "R6 bottom row key");
      else             key_test(r, c, e, "R4 digit key");
    end

    // R7 lowest row wins
    pressed = '0; pressed[1*4+0] = 1'b1; pressed[2*4+0] = 1'b1;
    wait_valid(got);
    chk(got && code == 4'h4, "R7 rows1,2 col0", int'(code), 4);
    pressed = '0; repeat (8) @(negedge clk);
    pressed[0*4+3] = 1'b1; pressed[3*4+3] = 1'b1;
    wait_valid(got);
    chk(got && code == 4'hA, "R7 rows0,3 col3", int'(code), 'hA);
    pressed = '0; repeat (8) @(negedge clk);

    // R8 back-pressure
    ready = 1'b0;
    pressed[2*4+1] = 1'b1;
    wait_valid(got);
    held = col_n;
    pressed = '0;
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (valid && code == 4'h8 && col_n == held) cnt++;
    end
    chk(cnt == 12, "R8 stall holds valid/code/column", cnt, 12);
    ready = 1'b1;
    @(negedge clk);
    chk(!valid, "R9 valid drops after transfer", int'(valid), 0);
    repeat (8) @(negedge clk);

    // R9 held key gives one code; column held until release
    pressed[1*4+2] = 1'b1;
    wait_valid(got);
    chk(got && code == 4'h6, "R9 first code", int'(code), 6);
    held = col_n;
    cnt = 0;
    for (int i = 0; i < 6 * SETTLE; i++) begin
      @(negedge clk);
      if (valid) cnt++;
      if (col_n != held) cnt += 100;
    end
    chk(cnt == 0, "R9 no repeat, column held", cnt, 0);
    pressed = '0;
    for (int i = 0; i < 6; i++) @(negedge clk);
    exp_col = {held[2:0], held[3]};
    chk(col_n == exp_col, "R9 resumes at next column", int'(col_n), int'(exp_col));

    // R10 short low early in window gives nothing
    while (col_n != 4'b1101) @(negedge clk);
    repeat (2) @(negedge clk);
    pressed[0*4+1] = 1'b1;
    repeat (3) @(negedge clk);
    pressed = '0;
    cnt = 0;
    for (int i = 0; i < 5 * SETTLE; i++) begin
      @(negedge clk);
      if (valid) cnt++;
    end
    chk(cnt == 0, "R10 early glitch ignored", cnt, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule